// File: doc/BRIEF.md
# Exception entry controller

This block manages the state changes a 32-bit core makes when it takes an exception or returns from one. Each cycle it looks at seven request lines: system reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. It also looks at a coprocessor-instruction qualifier, a return request, the current PC and the current program status word. When an event is accepted, the block does four things:

- picks the event's vector;
- records a return address and the old status word in the link and saved-status banks of the mode being entered;
- builds the new status word with the new mode and updated interrupt masks;
- pulses a flush to the fetch stage together with the new PC.

A return request reverses the step. It loads the PC from the current mode's link bank and restores the status word from that mode's saved-status bank.

The status word itself lives outside the block. The pipeline writes back `newCpsr` whenever `cpsrWr` is high, and presents the result on `curCpsr`. Mode field is bits [4:0], fast-interrupt mask F is bit 6, interrupt mask I is bit 7.

Top module: `trap_entry_unit`

## Requirements
- R1: An accepted exception sets `newPc` to `VEC_BASE` plus: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C. Offset 0x14 is never produced.
- R2: Simultaneous requests resolve in this order, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined, software interrupt.
- R3: The mode field of `newCpsr` on entry is 10011 for reset and software interrupt, 11011 for undefined, 10111 for both aborts, 10010 for normal interrupt and 10001 for fast interrupt.
- R4: Every entry sets bit 7 (I). Fast interrupt and reset also set bit 6 (F). Any other entry keeps bit 6 and bits [31:8] and bit 5 of `curCpsr`. A reset entry produces exactly 0x000000D3.
- R5: Every entry except reset writes `curPc`+8 (data abort) or `curPc`+4 (all others) into the link bank of the mode entered, and writes `curCpsr` into that mode's saved-status bank. A reset entry writes no bank.
- R6: With `cpOp` high, an undefined trap is raised unless `cpXfer` is high and `cpNum` equals `CTRL_CP`.
- R7: A normal-interrupt request is ignored while bit 7 of `curCpsr` is set. A fast-interrupt request is ignored while bit 6 is set.
- R8: A return request in a mode with banks (10001, 10010, 10011, 10111, 11011) sets `newPc` to that mode's link bank and `newCpsr` to its saved-status bank. In any other mode the request is ignored and no flush is raised.
- R9: Each of the five modes has its own banks, so entering one mode from another leaves the outer mode's saved PC and status word intact.
- R10: `flush` and `cpsrWr` are high for exactly the cycle after an accepted event and low otherwise. When an exception and a return are requested together, the exception wins.
- R11: While `rstN` is low, `flush` and `cpsrWr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low register reset |
| reqReset | input | 1 | Reset exception request |
| reqUndef | input | 1 | Undefined-instruction request |
| reqSwi | input | 1 | Software-interrupt request |
| reqPabt | input | 1 | Prefetch-abort request |
| reqDabt | input | 1 | Data-abort request |
| reqIrq | input | 1 | Normal interrupt request |
| reqFiq | input | 1 | Fast interrupt request |
| cpOp | input | 1 | Current instruction is a coprocessor instruction |
| cpXfer | input | 1 | The coprocessor instruction is a register transfer |
| cpNum | input | 4 | Coprocessor number addressed |
| retReq | input | 1 | Exception-return request |
| curPc | input | ADDR_W | Address of the instruction the event concerns |
| curCpsr | input | 32 | Current status word |
| flush | output | 1 | One-cycle redirect pulse to fetch |
| newPc | output | ADDR_W | Redirect target |
| cpsrWr | output | 1 | Status-word write strobe |
| newCpsr | output | 32 | Status word to write |

## Verification
Every result appears one clock after the requests are sampled: `flush`, `cpsrWr`, `newPc` and `newCpsr` are all registered, and bank writes land on that same edge. A return issued in the next cycle therefore already sees the banked values. The bench drives inputs on a falling edge and samples outputs on the following falling edge, one rising edge later. It then feeds the expected status word back into `curCpsr` before the next cycle. Because of this, every entry check, and the return check after it, looks exactly one register stage downstream of its stimulus.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int NUM_BANKS = 5;
  localparam logic [2:0] NO_BANK = 3'd7;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;

  localparam logic [31:0] RESET_CPSR = 32'h0000_00D3;

  // enum value is the vector slot; slot 5 is reserved and has no member
  typedef enum logic [2:0] {
    K_RST  = 3'd0,
    K_UND  = 3'd1,
    K_SWI  = 3'd2,
    K_PABT = 3'd3,
    K_DABT = 3'd4,
    K_IRQ  = 3'd6,
    K_FIQ  = 3'd7
  } excKind_t;

  typedef struct packed {
    logic     enter;
    logic     ret;
    excKind_t kind;
    logic [2:0] bank;
    logic     bankWr;
  } trapStrobes_t;

  function automatic logic [4:0] modeOf(excKind_t k);
    case (k)
      K_UND:          modeOf = MODE_UND;
      K_PABT, K_DABT: modeOf = MODE_ABT;
      K_IRQ:          modeOf = MODE_IRQ;
      K_FIQ:          modeOf = MODE_FIQ;
      default:        modeOf = MODE_SVC;
    endcase
  endfunction

  function automatic logic [2:0] bankOf(logic [4:0] m);
    case (m)
      MODE_SVC: bankOf = 3'd0;
      MODE_ABT: bankOf = 3'd1;
      MODE_UND: bankOf = 3'd2;
      MODE_IRQ: bankOf = 3'd3;
      MODE_FIQ: bankOf = 3'd4;
      default:  bankOf = NO_BANK;
    endcase
  endfunction

  function automatic logic [3:0] linkOff(excKind_t k);
    linkOff = (k == K_DABT) ? 4'd8 : 4'd4;
  endfunction

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int CTRL_CP = 15
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqReset,
  input  logic         reqUndef,
  input  logic         reqSwi,
  input  logic         reqPabt,
  input  logic         reqDabt,
  input  logic         reqIrq,
  input  logic         reqFiq,
  input  logic         cpOp,
  input  logic         cpXfer,
  input  logic [3:0]   cpNum,
  input  logic         retReq,
  input  logic [4:0]   curMode,
  input  logic         maskI,
  input  logic         maskF,
  output trapStrobes_t strb
);

  localparam logic [3:0] CTRL_CP_NUM = 4'(CTRL_CP);

  logic cpAllowed, undefEff, irqEff, fiqEff;
  logic [2:0] retBank;
  logic retOk;
  logic anyExc;
  excKind_t winner;

  assign cpAllowed = cpXfer && (cpNum == CTRL_CP_NUM);
  assign undefEff  = reqUndef || (cpOp && !cpAllowed);
  assign irqEff    = reqIrq && !maskI;
  assign fiqEff    = reqFiq && !maskF;
  assign anyExc    = reqReset || reqDabt || fiqEff || irqEff || reqPabt || undefEff || reqSwi;

  always_comb begin
    winner = K_SWI;
    if (reqReset)      winner = K_RST;
    else if (reqDabt)  winner = K_DABT;
    else if (fiqEff)   winner = K_FIQ;
    else if (irqEff)   winner = K_IRQ;
    else if (reqPabt)  winner = K_PABT;
    else if (undefEff) winner = K_UND;
  end

  assign retBank = bankOf(curMode);
  assign retOk   = retReq && (retBank != NO_BANK);

  always_comb begin
    strb.enter  = anyExc;
    strb.ret    = retOk && !anyExc;
    strb.kind   = winner;
    strb.bank   = anyExc ? bankOf(modeOf(winner)) : retBank;
    strb.bankWr = anyExc && (winner != K_RST);
  end

  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.enter && strb.ret));

  p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.enter && strb.kind == K_IRQ) |-> !maskI);

  p_fiq_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.enter && strb.kind == K_FIQ) |-> (!maskF && !reqReset && !reqDabt));

  p_ret_bank_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.ret |-> (strb.bank < 3'(NUM_BANKS)));

  p_cp_trap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpOp && !cpXfer) |-> strb.enter);

endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  trapStrobes_t      strb,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [31:0]       curCpsr,
  output logic              flush,
  output logic [ADDR_W-1:0] newPc,
  output logic              cpsrWr,
  output logic [31:0]       newCpsr
);

  localparam logic [ADDR_W-1:0] RSVD_VEC = VEC_BASE + ADDR_W'(5 * 4);

  logic [ADDR_W-1:0] linkBank [NUM_BANKS];
  logic [31:0]       spsrBank [NUM_BANKS];

  logic [ADDR_W-1:0] linkVal, vecAddr, retPc;
  logic [31:0]       entryCpsr, retCpsr;
  logic              setF;
  logic              entryQ;

  assign linkVal = curPc + ADDR_W'(linkOff(strb.kind));
  assign vecAddr = VEC_BASE + ADDR_W'({strb.kind, 2'b00});
  assign setF    = (strb.kind == K_FIQ) || curCpsr[6];

  always_comb begin
    if (strb.kind == K_RST)
      entryCpsr = RESET_CPSR;
    else
      entryCpsr = {curCpsr[31:8], 1'b1, setF, curCpsr[5], modeOf(strb.kind)};
  end

  always_comb begin
    retPc   = '0;
    retCpsr = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strb.bank == 3'(b)) begin
        retPc   = linkBank[b];
        retCpsr = spsrBank[b];
      end
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        linkBank[g] <= '0;
        spsrBank[g] <= '0;
      end else if (strb.bankWr && strb.bank == 3'(g)) begin
        linkBank[g] <= linkVal;
        spsrBank[g] <= curCpsr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flush   <= 1'b0;
      cpsrWr  <= 1'b0;
      entryQ  <= 1'b0;
      newPc   <= '0;
      newCpsr <= '0;
    end else begin
      flush  <= strb.enter || strb.ret;
      cpsrWr <= strb.enter || strb.ret;
      entryQ <= strb.enter;
      if (strb.enter) begin
        newPc   <= vecAddr;
        newCpsr <= entryCpsr;
      end else if (strb.ret) begin
        newPc   <= retPc;
        newCpsr <= retCpsr;
      end
    end
  end

  p_no_rsvd_vec_r1: assert property (@(posedge clk) disable iff (!rstN)
    (flush && entryQ) |-> (newPc != RSVD_VEC));

  p_entry_imask_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.enter |=> (newCpsr[7] && flush));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.enter || strb.ret) |=> (!flush && !cpsrWr));

  p_fiq_fmask_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.enter && (strb.kind == K_FIQ || strb.kind == K_RST)) |=> newCpsr[6]);

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0,
  parameter int                CTRL_CP  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqReset,
  input  logic              reqUndef,
  input  logic              reqSwi,
  input  logic              reqPabt,
  input  logic              reqDabt,
  input  logic              reqIrq,
  input  logic              reqFiq,
  input  logic              cpOp,
  input  logic              cpXfer,
  input  logic [3:0]        cpNum,
  input  logic              retReq,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [31:0]       curCpsr,
  output logic              flush,
  output logic [ADDR_W-1:0] newPc,
  output logic              cpsrWr,
  output logic [31:0]       newCpsr
);

  trapStrobes_t strb;

  trap_ctrl #(.CTRL_CP(CTRL_CP)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqReset (reqReset),
    .reqUndef (reqUndef),
    .reqSwi   (reqSwi),
    .reqPabt  (reqPabt),
    .reqDabt  (reqDabt),
    .reqIrq   (reqIrq),
    .reqFiq   (reqFiq),
    .cpOp     (cpOp),
    .cpXfer   (cpXfer),
    .cpNum    (cpNum),
    .retReq   (retReq),
    .curMode  (curCpsr[4:0]),
    .maskI    (curCpsr[7]),
    .maskF    (curCpsr[6]),
    .strb     (strb)
  );

  trap_datapath #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .curPc   (curPc),
    .curCpsr (curCpsr),
    .flush   (flush),
    .newPc   (newPc),
    .cpsrWr  (cpsrWr),
    .newCpsr (newCpsr)
  );

endmodule

// File: tb/trap_entry_unit_test.sv
`timescale 1ns/1ps
module trap_entry_unit_test;

  logic clk = 1'b0;
  logic rstN;
  logic reqReset, reqUndef, reqSwi, reqPabt, reqDabt, reqIrq, reqFiq;
  logic cpOp, cpXfer;
  logic [3:0] cpNum;
  logic retReq;
  logic [31:0] curPc, curCpsr;
  logic flush, cpsrWr;
  logic [31:0] newPc, newCpsr;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  trap_entry_unit uut (
    .clk(clk), .rstN(rstN),
    .reqReset(reqReset), .reqUndef(reqUndef), .reqSwi(reqSwi),
    .reqPabt(reqPabt), .reqDabt(reqDabt), .reqIrq(reqIrq), .reqFiq(reqFiq),
    .cpOp(cpOp), .cpXfer(cpXfer), .cpNum(cpNum), .retReq(retReq),
    .curPc(curPc), .curCpsr(curCpsr),
    .flush(flush), .newPc(newPc), .cpsrWr(cpsrWr), .newCpsr(newCpsr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic clearIn();
    {reqReset, reqUndef, reqSwi, reqPabt, reqDabt, reqIrq, reqFiq} = '0;
    cpOp = 0; cpXfer = 0; cpNum = 0; retReq = 0;
  endtask

  // bits: 0 reset,1 undef,2 swi,3 pabt,4 dabt,5 irq,6 fiq
  task automatic drive(input logic [6:0] r);
    {reqFiq, reqIrq, reqDabt, reqPabt, reqSwi, reqUndef, reqReset} = r;
  endtask

  // one rising edge passes; outputs then sampled at the falling edge
  task automatic step();
    @(negedge clk);
  endtask

  function automatic int winner(logic [6:0] r, logic mi, logic mf);
    if (r[0]) return 0;
    if (r[4]) return 4;
    if (r[6] && !mf) return 7;
    if (r[5] && !mi) return 6;
    if (r[3]) return 3;
    if (r[1]) return 1;
    if (r[2]) return 2;
    return -1;
  endfunction

  function automatic logic [4:0] expMode(int k);
    case (k)
      1: return 5'b11011;
      3, 4: return 5'b10111;
      6: return 5'b10010;
      7: return 5'b10001;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] expCpsr(int k, logic [31:0] c);
    if (k == 0) return 32'h0000_00D3;
    return {c[31:8], 1'b1, (c[6] || k == 7), c[5], expMode(k)};
  endfunction

  // enter, check R1..R4 / R10; then return and check R5 / R8
  task automatic entryAndReturn(input logic [6:0] r, input logic [31:0] pc, input logic [31:0] c);
    int k;
    logic [31:0] ec;
    k = winner(r, c[7], c[6]);
    curPc = pc; curCpsr = c; drive(r);
    step();
    clearIn();
    if (k < 0) begin
      chk(flush == 0, "R7 masked request ignored", {31'b0, flush}, 32'h0);
      return;
    end
    ec = expCpsr(k, c);
    chk(flush && cpsrWr, "R10 flush on entry", {30'b0, flush, cpsrWr}, 32'h3);
    chk(newPc == 32'(k * 4), "R1 R2 vector", newPc, 32'(k * 4));
    chk(newCpsr == ec, "R3 R4 entry status", newCpsr, ec);
    if (k == 0) begin
      step();
      return;
    end
    curCpsr = ec; curPc = 32'hDEAD_0000; retReq = 1;
    step();
    clearIn();
    chk(flush, "R8 return flush", {31'b0, flush}, 32'h1);
    chk(newPc == pc + ((k == 4) ? 32'd8 : 32'd4), "R5 link value", newPc, pc + ((k == 4) ? 32'd8 : 32'd4));
    chk(newCpsr == c, "R5 saved status", newCpsr, c);
    step();
    chk(flush == 0 && cpsrWr == 0, "R10 single-cycle pulse", {30'b0, flush, cpsrWr}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rstN = 0; clearIn(); curPc = 0; curCpsr = 32'h10;
    reqReset = 1;
    repeat (3) step();
    chk(flush == 0 && cpsrWr == 0, "R11 reset outputs", {30'b0, flush, cpsrWr}, 32'h0);
    clearIn();
    rstN = 1;
    step();
    chk(flush == 0, "R11 idle after reset", {31'b0, flush}, 32'h0);

    // R1 R2 R3 R4 R5 R7 sweep: every request mix under every mask setting
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 128; r++) begin
        logic [31:0] c;
        c = 32'h5000_0030 | (m[1] ? 32'h80 : 32'h0) | (m[0] ? 32'h40 : 32'h0);
        entryAndReturn(7'(r), 32'h0001_0000 + 32'(r * 16 + m * 4096), c);
      end
    end

    // R6 coprocessor qualification sweep
    for (int x = 0; x < 2; x++) begin
      for (int n = 0; n < 16; n++) begin
        bit trap;
        trap = !(x == 1 && n == 15);
        curCpsr = 32'h10; curPc = 32'h200;
        cpOp = 1; cpXfer = 1'(x); cpNum = 4'(n);
        step();
        clearIn();
        chk(flush == trap, "R6 coprocessor trap", {31'b0, flush}, {31'b0, trap});
        if (trap) chk(newPc == 32'h4, "R6 undefined vector", newPc, 32'h4);
        step();
      end
    end

    // R9 nesting: normal interrupt, then fast interrupt, unwind both
    curCpsr = 32'h10; curPc = 32'h3000; drive(7'h20);
    step(); clearIn();
    chk(newCpsr == 32'h92, "R9 irq entry", newCpsr, 32'h92);
    curCpsr = 32'h92; curPc = 32'h4000; drive(7'h40);
    step(); clearIn();
    chk(newCpsr == 32'hD1, "R9 fiq nested entry", newCpsr, 32'hD1);
    curCpsr = 32'hD1; retReq = 1;
    step(); clearIn();
    chk(newPc == 32'h4004, "R9 fiq return pc", newPc, 32'h4004);
    chk(newCpsr == 32'h92, "R9 fiq return status", newCpsr, 32'h92);
    curCpsr = 32'h92; retReq = 1;
    step(); clearIn();
    chk(newPc == 32'h3004, "R9 irq bank intact pc", newPc, 32'h3004);
    chk(newCpsr == 32'h10, "R9 irq bank intact status", newCpsr, 32'h10);

    // R5 reset entry leaves supervisor bank untouched
    curCpsr = 32'h10; curPc = 32'h5000; drive(7'h04);
    step(); clearIn();
    curCpsr = 32'h93; curPc = 32'h9999; drive(7'h01);
    step(); clearIn();
    chk(newCpsr == 32'hD3, "R4 reset status", newCpsr, 32'hD3);
    curCpsr = 32'hD3; retReq = 1;
    step(); clearIn();
    chk(newPc == 32'h5004, "R5 reset writes no bank", newPc, 32'h5004);

    // R8 return in user and system modes is ignored
    curCpsr = 32'h10; retReq = 1;
    step(); clearIn();
    chk(flush == 0 && cpsrWr == 0, "R8 return in user ignored", {30'b0, flush, cpsrWr}, 32'h0);
    curCpsr = 32'h1F; retReq = 1;
    step(); clearIn();
    chk(flush == 0, "R8 return in system ignored", {31'b0, flush}, 32'h0);

    // R10 exception outranks a simultaneous return
    curCpsr = 32'h93; curPc = 32'h6000; retReq = 1; drive(7'h08);
    step(); clearIn();
    chk(newPc == 32'h0C, "R10 exception beats return", newPc, 32'h0C);
    chk(newCpsr == 32'h97, "R10 exception status", newCpsr, 32'h97);
    step();

    report();
  end

endmodule